// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a two-operand integer arithmetic unit for a 64-bit data path. A lane-size input decides at run time whether the operands are handled as eight 8-bit values, four 16-bit values, two 32-bit values or one 64-bit value. A single opcode then acts on every lane at once. There are three forms of add and of subtract: plain modular arithmetic, clamping to the signed range and clamping to the unsigned range. There are also three full-width bitwise operations.

The arithmetic sits on one adder cut into byte slices. At each lane boundary the carry chain is broken, and the carry-in there is forced to the value the operation needs. A clamp stage reads the carry and sign bits of each lane's top byte and replaces the lane with its limit when the exact result does not fit. The result is captured in a register together with a valid flag. Because of this, a strobe on cycle N shows up at the outputs after the clock edge that ends cycle N.

Top module: `simd_alu`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low after an edge at which it was low.
- R2: Reset (active-low, asynchronous) clears `result` to zero and `out_valid` to low. After reset, `result` loads only at an edge where `in_valid` is high and holds its value at every other edge.
- R3: `lane_sel` encodes the lane width as 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Lane k of width w occupies bits [k*w+w-1 : k*w].
- R4: Opcode 0 (wrapping add) adds each lane modulo 2^w, and no carry passes into the next lane.
- R5: Opcode 1 (wrapping subtract) computes op_a minus op_b in each lane modulo 2^w, and no borrow passes into the next lane.
- R6: Opcodes 2 (signed-saturating add) and 3 (signed-saturating subtract) clamp each 8-bit or 16-bit lane to the range from -2^(w-1) to 2^(w-1)-1.
- R7: Opcodes 4 (unsigned-saturating add) and 5 (unsigned-saturating subtract) clamp each 8-bit or 16-bit lane to the range from 0 to 2^w-1.
- R8: With 32-bit or 64-bit lanes, opcodes 2 and 4 behave exactly like opcode 0, and opcodes 3 and 5 behave exactly like opcode 1.
- R9: Opcodes 6 (AND), 7 (OR) and 8 (XOR) act on all 64 bits, whatever the value of `lane_sel`.
- R10: Opcodes 9 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that marks the operands and opcode as valid |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (the subtrahend) |
| opcode | input | 4 | Operation select |
| lane_sel | input | 2 | Lane width select |
| out_valid | output | 1 | High one cycle after an accepted strobe |
| result | output | 64 | Registered result |

## Verification
The checker tests the following on every cycle:
- the one-cycle valid timing and the holding of the result between strobes;
- that the number of lane heads the adder marks agrees with `lane_sel`;
- that no clamp fires for a wide lane or for a non-saturating opcode;
- the full-width AND, the single-lane 64-bit add and the zeroing for unused opcodes.

The clamp values themselves, and the cutting of carries and borrows at 8-, 16- and 32-bit boundaries, can only be shown by the bench. It does this with hand-worked vectors at the range edges and with a per-lane reference model that is swept across every opcode and lane width.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } lane_sz_e;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDS = 4'd2,
    OP_SUBS = 4'd3,
    OP_ADDU = 4'd4,
    OP_SUBU = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8
  } alu_op_e;

  // Operation uses the inverted second operand plus one.
  function automatic logic op_is_sub(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBS) || (op == OP_SUBU);
  endfunction

  function automatic logic op_is_ssat(input alu_op_e op);
    return (op == OP_ADDS) || (op == OP_SUBS);
  endfunction

  function automatic logic op_is_usat(input alu_op_e op);
    return (op == OP_ADDU) || (op == OP_SUBU);
  endfunction

  function automatic logic op_is_arith(input alu_op_e op);
    return op <= OP_SUBU;
  endfunction

  // True when byte slice idx is the lowest byte of its lane.
  function automatic logic seg_head(input int idx, input logic [1:0] ls);
    int span;
    span = 1 << ls;
    return (idx % span) == 0;
  endfunction

  // Saturation is only defined for lanes of one or two bytes.
  function automatic logic lane_can_clamp(input logic [1:0] ls);
    return ls inside {LANE_B8, LANE_B16};
  endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_alu_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic [1:0]    lane_sel,
  output logic [DW-1:0] b_eff,
  output logic [DW-1:0] sum,
  output logic [NB-1:0] cout,
  output logic [NB-1:0] seg_start
);

  logic [NB-1:0] cin;

  assign b_eff = sub ? ~b : b;

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign seg_start[g] = seg_head(g, lane_sel);
    if (g == 0) begin : g_first
      assign cin[g] = sub;
    end else begin : g_rest
      // Carry chain is cut at every lane head.
      assign cin[g] = seg_start[g] ? sub : cout[g-1];
    end
    assign {cout[g], sum[g*BW +: BW]} = {1'b0, a[g*BW +: BW]}
                                      + {1'b0, b_eff[g*BW +: BW]}
                                      + {{BW{1'b0}}, cin[g]};
  end

endmodule

// File: rtl/simd_sat_unit.sv
module simd_sat_unit
  import simd_alu_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b_eff,
  input  logic [DW-1:0] sum,
  input  logic [NB-1:0] cout,
  input  logic [1:0]    lane_sel,
  input  logic          sub,
  input  logic          sat_signed,
  input  logic          sat_unsigned,
  output logic [DW-1:0] res,
  output logic [NB-1:0] sat_hit
);

  logic small_lane;
  assign small_lane = lane_can_clamp(lane_sel);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int T8  = g;
    localparam int T16 = ((g | 1) < NB) ? (g | 1) : g;

    logic t_a_msb, t_b_msb, t_s_msb, t_cout, is_top;
    logic s_ovf, u_ovf;
    logic [BW-1:0] s_clamp, u_clamp;

    assign t_a_msb = (lane_sel == LANE_B8) ? a[T8*BW+BW-1]     : a[T16*BW+BW-1];
    assign t_b_msb = (lane_sel == LANE_B8) ? b_eff[T8*BW+BW-1] : b_eff[T16*BW+BW-1];
    assign t_s_msb = (lane_sel == LANE_B8) ? sum[T8*BW+BW-1]   : sum[T16*BW+BW-1];
    assign t_cout  = (lane_sel == LANE_B8) ? cout[T8]          : cout[T16];
    assign is_top  = (lane_sel == LANE_B8) || (g == T16);

    // Signed overflow: addend signs agree and the sum sign differs.
    assign s_ovf = (t_a_msb == t_b_msb) && (t_s_msb != t_a_msb);
    // Unsigned: carry out on add, missing carry (borrow) on subtract.
    assign u_ovf = sub ? ~t_cout : t_cout;

    assign sat_hit[g] = small_lane &&
                        ((sat_signed && s_ovf) || (sat_unsigned && u_ovf));

    assign s_clamp = is_top ? {t_a_msb, {(BW-1){~t_a_msb}}} : {BW{~t_a_msb}};
    assign u_clamp = {BW{~sub}};

    assign res[g*BW +: BW] = !sat_hit[g]  ? sum[g*BW +: BW] :
                             sat_signed   ? s_clamp : u_clamp;
  end

endmodule

// File: rtl/simd_logic_unit.sv
module simd_logic_unit #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    fn,
  output logic [DW-1:0] y
);

  always_comb begin
    case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NB = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        opcode,
  input  logic [1:0]        lane_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  alu_op_e op;
  assign op = alu_op_e'(opcode);

  // Named internal events, observed by the bound checker.
  logic [DATA_W-1:0] b_eff, raw_sum, arith_res, logic_res, next_res;
  logic [NB-1:0]     byte_carry, lane_start, sat_hit;
  logic              do_sub, arith_sel;
  logic [1:0]        logic_fn;

  assign do_sub    = op_is_sub(op);
  assign arith_sel = op_is_arith(op);
  assign logic_fn  = (op == OP_AND) ? 2'd0 : (op == OP_OR) ? 2'd1 : 2'd2;

  simd_seg_adder #(.NB(NB), .BW(BYTE_W)) u_add (
    .a         (op_a),
    .b         (op_b),
    .sub       (do_sub),
    .lane_sel  (lane_sel),
    .b_eff     (b_eff),
    .sum       (raw_sum),
    .cout      (byte_carry),
    .seg_start (lane_start)
  );

  simd_sat_unit #(.NB(NB), .BW(BYTE_W)) u_sat (
    .a            (op_a),
    .b_eff        (b_eff),
    .sum          (raw_sum),
    .cout         (byte_carry),
    .lane_sel     (lane_sel),
    .sub          (do_sub),
    .sat_signed   (op_is_ssat(op)),
    .sat_unsigned (op_is_usat(op)),
    .res          (arith_res),
    .sat_hit      (sat_hit)
  );

  simd_logic_unit #(.DW(DATA_W)) u_log (
    .a  (op_a),
    .b  (op_b),
    .fn (logic_fn),
    .y  (logic_res)
  );

  always_comb begin
    if (arith_sel)
      next_res = arith_res;
    else if (op inside {OP_AND, OP_OR, OP_XOR})
      next_res = logic_res;
    else
      next_res = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid)
        result <= next_res;
    end
  end

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64,
  parameter int NB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [3:0]        opcode,
  input logic [1:0]        lane_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [NB-1:0]     lane_start,
  input logic [NB-1:0]     sat_hit
);

  logic sat_op;
  assign sat_op = (opcode >= 4'd2) && (opcode <= 4'd5);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_start) == (NB >> lane_sel));

  assert_no_wide_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel[1] || !sat_op) |-> (sat_hit == '0));

  assert_wide_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd0 && lane_sel == 2'd3) |=> result == $past(op_a + op_b));

  assert_and_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd6) |=> result == $past(op_a & op_b));

  assert_unused_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > 4'd8) |=> result == '0);

endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .NB(NB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_a       (op_a),
  .op_b       (op_b),
  .opcode     (opcode),
  .lane_sel   (lane_sel),
  .out_valid  (out_valid),
  .result     (result),
  .lane_start (lane_start),
  .sat_hit    (sat_hit)
);

// File: tb/simd_alu_test.sv
module simd_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_sel = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  simd_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane_sel(lane_sel), .out_valid(out_valid), .result(result)
  );

  // {opcode, lane_sel, a, b, expected}
  localparam int NV = 16;
  localparam logic [197:0] VEC [NV] = '{
    {4'd0, 2'd0, 64'hFF, 64'h1, 64'h0},                                    // R4
    {4'd0, 2'd3, 64'hFF, 64'h1, 64'h100},                                  // R4
    {4'd0, 2'd1, 64'hFFFF, 64'h1, 64'h0},                                  // R4
    {4'd0, 2'd2, 64'hFFFF, 64'h1, 64'h10000},                              // R4
    {4'd1, 2'd0, 64'h0, 64'h1, 64'hFF},                                    // R5
    {4'd1, 2'd3, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF},                   // R5
    {4'd2, 2'd0, 64'h807F, 64'hFF01, 64'h807F},                            // R6
    {4'd3, 2'd1, 64'h7FFF_8000, 64'hFFFF_0001, 64'h7FFF_8000},             // R6
    {4'd4, 2'd0, 64'h10F0, 64'h2020, 64'h30FF},                            // R7
    {4'd5, 2'd1, 64'h0010_0005, 64'h0005_0010, 64'h000B_0000},             // R7
    {4'd4, 2'd2, 64'hFFFF_FFFF, 64'h1, 64'h0},                             // R8
    {4'd2, 2'd3, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000}, // R8
    {4'd6, 2'd0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000}, // R9
    {4'd7, 2'd2, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0F0F_0F0F_0F0F, 64'hFFFF_FFFF_FFFF_FFFF}, // R9
    {4'd8, 2'd1, 64'hFFFF_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 64'h00FF_FF00_00FF_FF00}, // R9
    {4'd9, 2'd0, 64'h1234, 64'h1, 64'h0}                                   // R10
  };
  localparam int VREQ [NV] = '{4, 4, 4, 4, 5, 5, 6, 6, 7, 7, 8, 8, 9, 9, 9, 10};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent per-lane reference, built on wide integer arithmetic.
  function automatic logic [63:0] ref_model(input logic [3:0] op, input logic [1:0] ls,
                                            input logic [63:0] a, input logic [63:0] b);
    int w, n;
    logic [63:0] res;
    logic [65:0] mask;
    if (op == 4'd6) return a & b;
    if (op == 4'd7) return a | b;
    if (op == 4'd8) return a ^ b;
    if (op > 4'd8)  return '0;
    w = 8 << ls;
    n = 64 / w;
    mask = {66{1'b1}} >> (66 - w);
    res = '0;
    for (int k = 0; k < n; k++) begin
      logic [65:0] ua, ub, ur;
      logic signed [65:0] sa, sb, sr, hi, lo;
      ua = (66'(a) >> (k * w)) & mask;
      ub = (66'(b) >> (k * w)) & mask;
      sa = ua[w-1] ? signed'(ua | ~mask) : signed'(ua);
      sb = ub[w-1] ? signed'(ub | ~mask) : signed'(ub);
      hi = signed'(mask >> 1);
      lo = ~hi;
      case (op)
        4'd0: ur = ua + ub;
        4'd1: ur = ua - ub;
        4'd2, 4'd3: begin
          sr = (op == 4'd2) ? sa + sb : sa - sb;
          if (w <= 16 && sr > hi) sr = hi;
          if (w <= 16 && sr < lo) sr = lo;
          ur = unsigned'(sr);
        end
        4'd4: begin
          ur = ua + ub;
          if (w <= 16 && ur > mask) ur = mask;
        end
        default: ur = (w <= 16 && ua < ub) ? 66'd0 : ua - ub;
      endcase
      res = res | 64'((ur & mask) << (k * w));
    end
    return res;
  endfunction

  // Present one strobe at a falling edge; outputs are read at the next falling edge.
  task automatic apply(input logic [3:0] op, input logic [1:0] ls,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    opcode = op; lane_sel = ls; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y, held;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset result", result, 64'h0);
    check("R1 reset valid", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][197:194], VEC[i][193:192], VEC[i][191:128], VEC[i][127:64]);
      check($sformatf("R%0d vector %0d", VREQ[i], i), result, VEC[i][63:0]);
      check("R1 valid after strobe", 64'(out_valid), 64'h1);
    end

    // R2/R1: idle cycles with changing inputs leave result unchanged
    held = result;
    @(negedge clk);
    check("R1 valid low when idle", 64'(out_valid), 64'h0);
    opcode = 4'd7; op_a = '1; op_b = '1; lane_sel = 2'd3;
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", result, held);

    // R9: lane_sel does not change logic results
    for (int ls = 0; ls < 4; ls++) begin
      apply(4'd8, 2'(ls), 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_F0F0_0F0F);
      check("R9 xor any lane size", result, 64'h0123_4567_89AB_CDEF ^ 64'hFFFF_0000_F0F0_0F0F);
    end

    // R6/R7: every lane clamped at once
    apply(4'd2, 2'd0, 64'h7F7F_7F7F_8080_8080, 64'h0101_0101_FFFF_FFFF);
    check("R6 all-byte signed clamp", result, 64'h7F7F_7F7F_8080_8080);
    apply(4'd5, 2'd1, 64'h0000_0001_0002_0003, 64'h0001_0002_0003_0004);
    check("R7 all-lane unsigned floor", result, 64'h0);
    apply(4'd4, 2'd1, 64'hFFFF_8000_0001_FFFE, 64'h0001_8000_FFFF_0001);
    check("R7 unsigned ceiling 16", result, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5/R3: borrow stopped at 32-bit boundary
    apply(4'd1, 2'd2, 64'h0000_0005_0000_0000, 64'h0000_0000_0000_0001);
    check("R5 borrow cut at lane 1 R3", result, 64'h0000_0005_FFFF_FFFF);

    // Sweep against the reference model
    x = 64'h9E37_79B9_7F4A_7C15;
    y = 64'hD1B5_4A32_D192_ED03;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic [1:0] ls;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      y = y ^ (y << 13); y = y ^ (y >> 7); y = y ^ (y << 17);
      op = 4'(i % 11);
      ls = 2'((i / 11) % 4);
      if (i % 5 == 0) x = x | 64'h7F7F_7F7F_7F7F_7F7F;
      apply(op, ls, x, y);
      check($sformatf("R3 model op %0d lanes %0d (R4 R5 R6 R7 R8)", op, ls),
            result, ref_model(op, ls, x, y));
    end

    // R2: asynchronous reset mid-run
    apply(4'd7, 2'd0, 64'h1, 64'h2);
    #1 rst_n = 1'b0;
    #1;
    check("R2 async reset result", result, 64'h0);
    check("R2 async reset valid", 64'(out_valid), 64'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule